// File: doc/BRIEF.md
# Bus-to-Physical DMA Window Translator

This block sits between an inbound DMA master and the memory side. It turns a 32-bit bus address into a physical address. Four programmable windows are held in the block. Each window has three registers: a base (which also carries an enable flag and a mode flag), a size mask, and a translated base. An address that falls inside an enabled window is translated in one of two ways. In direct mode, the translated base is added to the offset inside the window. In scatter-gather mode, the block reads a page-table entry through a request/response port and builds the address from the frame number in that entry.

A separate control flag opens a large bypass window for dual-address (64-bit) accesses. These pass straight through without any window lookup. An address that matches no window, or a page-table entry whose valid bit is clear, produces a one-cycle fault pulse instead of an address. The block accepts one request at a time. Window registers are programmed through a plain write port.

Top module: `dma_window_xlat`

## Requirements
- R1: After reset, all outputs are idle (`out_valid`, `fault` and `pte_req` are low, `req_ready` is high). All windows are disabled and the bypass is off, so any request faults.
- R2: A write with `cfg_we` high stores `cfg_wdata` into window `cfg_sel`. `cfg_reg` selects the register: 0 = base, 1 = mask, 2 = translated base. `cfg_reg`=3 writes the control register, where bit 0 enables the dual-address bypass.
- R3: A window matches when its base bit 0 is set and `req_addr[31:20]` equals base bits 31:20 on every position where mask bits 31:20 are zero. Mask bits 19:0 are ignored, which gives 1 MB granularity; the mask is written as size minus one.
- R4: When several enabled windows match, the lowest-numbered one is used.
- R5: In direct mode (base bit 1 clear), `out_valid` pulses one cycle after acceptance. `out_pa` = translated base + (`req_addr` AND {mask[31:20], 20 ones}).
- R6: In scatter-gather mode (base bit 1 set), `pte_req` pulses for one cycle, one cycle after acceptance. `pte_addr` = translated base + 4 × (window offset >> 13).
- R7: Window 3 always translates in scatter-gather mode, whatever its base bit 1 holds.
- R8: When `pte_rsp_valid` arrives with PTE bit 0 set, `out_valid` pulses on the next cycle. `out_pa` = ((PTE >> 1) << 13) OR `req_addr[12:0]`, truncated to 40 bits.
- R9: A miss, or a PTE with bit 0 clear, gives a `fault` pulse exactly one cycle long; `out_valid` stays low for that request.
- R10: A request with `req_dac` high bypasses the windows. If the control bypass bit is set, `out_pa` = {`req_addr_hi`, `req_addr`} one cycle later. If it is clear, the request faults.
- R11: `req_ready` is high only while no page-table fetch is outstanding. A request is accepted when `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Window number for the write |
| cfg_reg | input | 2 | Register within the window (3 = control) |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Inbound request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address (low 32 bits) |
| req_addr_hi | input | 8 | Upper address bits for dual-address accesses |
| req_dac | input | 1 | Request is a dual-address access |
| pte_req | output | 1 | Page-table entry fetch strobe |
| pte_addr | output | 40 | Physical address of the entry |
| pte_rsp_valid | input | 1 | Entry data returned |
| pte_rsp_data | input | 32 | Entry data: bit 0 valid, bits 31:1 frame number |
| out_valid | output | 1 | Translated address valid (one cycle) |
| out_pa | output | 40 | Translated physical address |
| fault | output | 1 | Translation fault (one cycle) |

## Verification
The hardest case to reach from the ports is several overlapping windows in different modes matching the same address. The bench programs a scatter-gather window over a direct window's range to create this. It checks that the lower-numbered direct window wins. It then disables that window and checks that the same address falls through to a page-table fetch. Invalid page-table entries are produced by a bench-side entry model that clears the valid bit whenever address bits 3:2 are both set, so table stimulus can select valid and invalid fetches at will.

// File: rtl/dma_window_xlat.sv
module dma_window_xlat #(
  parameter int AW          = 32,
  parameter int PA_W        = 40,
  parameter int NWIN        = 4,
  parameter int PAGE_SHIFT  = 13,
  parameter int SEG_LSB     = 20,
  parameter int PTE_W       = 32,
  parameter int PTE_LOG     = 2,
  parameter int SG_ONLY_WIN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [1:0]      cfg_reg,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [PA_W-AW-1:0] req_addr_hi,
  input  logic            req_dac,
  output logic            pte_req,
  output logic [PA_W-1:0] pte_addr,
  input  logic            pte_rsp_valid,
  input  logic [PTE_W-1:0] pte_rsp_data,
  output logic            out_valid,
  output logic [PA_W-1:0] out_pa,
  output logic            fault
);

  localparam int SEL_W = $clog2(NWIN);
  localparam logic [AW-1:0] SEG_MASK = {{(AW-SEG_LSB){1'b1}}, {SEG_LSB{1'b0}}};

  typedef enum logic {ST_IDLE, ST_WAIT} st_t;

  logic [AW-1:0] base_q [NWIN];
  logic [AW-1:0] mask_q [NWIN];
  logic [AW-1:0] xlat_q [NWIN];
  logic          dac_en_q;

  st_t                 st;
  logic [PAGE_SHIFT-1:0] pg_off_q;

  logic [NWIN-1:0] hit, sg;
  logic [AW-1:0]   off [NWIN];
  logic [SEL_W-1:0] sel;
  logic            any_hit;
  logic [PA_W-1:0] direct_pa, table_addr;
  logic            acc;

  assign req_ready = (st == ST_IDLE);
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        xlat_q[i] <= '0;
      end
      dac_en_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_reg)
        2'd0: base_q[cfg_sel] <= cfg_wdata;
        2'd1: mask_q[cfg_sel] <= cfg_wdata & SEG_MASK;
        2'd2: xlat_q[cfg_sel] <= cfg_wdata;
        default: dac_en_q <= cfg_wdata[0];
      endcase
    end
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w] = base_q[w][0] &&
                    (((req_addr ^ base_q[w]) & ~mask_q[w] & SEG_MASK) == '0);
    assign sg[w]  = base_q[w][1] || (w == SG_ONLY_WIN);
    assign off[w] = req_addr & (mask_q[w] | ~SEG_MASK);
  end

  always_comb begin
    sel = '0;
    for (int i = NWIN-1; i >= 0; i--)
      if (hit[i]) sel = i[SEL_W-1:0];
  end

  assign any_hit    = |hit;
  assign direct_pa  = PA_W'(xlat_q[sel]) + PA_W'(off[sel]);
  assign table_addr = PA_W'(xlat_q[sel]) + (PA_W'(off[sel] >> PAGE_SHIFT) << PTE_LOG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      out_valid <= 1'b0;
      out_pa    <= '0;
      fault     <= 1'b0;
      pte_req   <= 1'b0;
      pte_addr  <= '0;
      pg_off_q  <= '0;
    end else begin
      out_valid <= 1'b0;
      fault     <= 1'b0;
      pte_req   <= 1'b0;
      case (st)
        ST_IDLE: if (acc) begin
          if (req_dac) begin
            if (dac_en_q) begin
              out_valid <= 1'b1;
              out_pa    <= {req_addr_hi, req_addr};
            end else
              fault <= 1'b1;
          end else if (!any_hit)
            fault <= 1'b1;
          else if (sg[sel]) begin
            pte_req  <= 1'b1;
            pte_addr <= table_addr;
            pg_off_q <= req_addr[PAGE_SHIFT-1:0];
            st       <= ST_WAIT;
          end else begin
            out_valid <= 1'b1;
            out_pa    <= direct_pa;
          end
        end
        default: if (pte_rsp_valid) begin
          st <= ST_IDLE;
          if (pte_rsp_data[0]) begin
            out_valid <= 1'b1;
            out_pa    <= PA_W'({pte_rsp_data[PTE_W-1:1], pg_off_q});
          end else
            fault <= 1'b1;
        end
      endcase
    end
  end

  // R9
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && out_valid));

  // R6
  pte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req |=> !pte_req);

  // R11
  busy_while_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req |-> !req_ready);

  // R10
  dac_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_dac && dac_en_q) |=> (out_valid && out_pa == $past({req_addr_hi, req_addr})));

  // R9
  result_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || fault) |-> $past(req_valid || pte_rsp_valid));

endmodule

// File: tb/dma_window_xlat_tb.sv
module dma_window_xlat_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // kind: 0 direct, 1 scatter-gather valid, 2 fault (miss), 3 scatter-gather invalid PTE
  localparam logic [31:0] V_ADDR [NV] = '{32'h8000_1234, 32'hBFFF_FFFC, 32'h0080_4000,
    32'h00FF_E010, 32'hC000_A000, 32'h0405_2000, 32'h0000_1000, 32'h4000_0000,
    32'h0410_0000, 32'h8000_0040};
  localparam logic V_DAC [NV] = '{0,0,0,0,0,0,0,0,0,1};
  localparam int V_KIND [NV] = '{0,0,1,3,1,1,2,2,2,2};
  localparam logic [39:0] V_EXP [NV] = '{40'h00_1000_1234, 40'h00_4FFF_FFFC, 40'h00_0010_0008,
    40'h00_0010_0FFC, 40'h00_0020_0014, 40'h00_0030_00A4, 40'h0, 40'h0, 40'h0, 40'h0};
  localparam string V_TAG [NV] = '{"R5", "R5", "R6", "R9", "R6", "R7", "R9", "R3", "R3", "R10"};

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0, cfg_reg = 0; logic [31:0] cfg_wdata = 0;
  logic req_valid = 0, req_ready, req_dac = 0;
  logic [31:0] req_addr = 0; logic [7:0] req_addr_hi = 0;
  logic pte_req, pte_rsp_valid = 0; logic [39:0] pte_addr; logic [31:0] pte_rsp_data = 0;
  logic out_valid, fault; logic [39:0] out_pa;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_window_xlat u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_addr_hi(req_addr_hi), .req_dac(req_dac), .pte_req(pte_req),
    .pte_addr(pte_addr), .pte_rsp_valid(pte_rsp_valid), .pte_rsp_data(pte_rsp_data),
    .out_valid(out_valid), .out_pa(out_pa), .fault(fault));

  function automatic logic [31:0] pte_of(input logic [39:0] a);
    logic [30:0] pfn;
    pfn = {1'b0, a[31:2]} ^ 31'h5A5;
    return {pfn, (a[3:2] != 2'b11)};
  endfunction

  function automatic logic [39:0] sg_pa(input logic [39:0] a, input logic [31:0] va);
    logic [63:0] p;
    p = ({32'h0, pte_of(a)} >> 1) << 13 | {51'h0, va[12:0]};
    return p[39:0];
  endfunction

  task automatic check(input logic ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [1:0] r, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_reg = r; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  // PTE memory model
  initial begin
    forever begin
      @(negedge clk);
      if (pte_req) begin
        logic [39:0] a;
        a = pte_addr;
        repeat (2) @(negedge clk);
        pte_rsp_data = pte_of(a); pte_rsp_valid = 1;
        @(negedge clk); pte_rsp_valid = 0;
      end
    end
  end

  task automatic run_req(input logic [31:0] a, input logic [7:0] hi, input logic dac,
                         input int kind, input logic [39:0] exp, input string tag);
    logic got_pte = 0, ready_seen = 0; logic [39:0] pa_seen = 0; int n = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_addr_hi = hi; req_dac = dac;
    check(req_ready == 1, "R11", {39'h0, req_ready}, 40'h1);
    @(negedge clk); req_valid = 0;
    while (!(out_valid || fault) && n < 40) begin
      if (pte_req) begin got_pte = 1; pa_seen = pte_addr; end
      else if (got_pte && !ready_seen) begin
        ready_seen = 1;
        check(req_ready == 0, "R11", {39'h0, req_ready}, 40'h0);
      end
      @(negedge clk); n++;
    end
    if (kind == 0) begin
      check(out_valid && !fault && out_pa == exp, tag, out_pa, exp);
    end else if (kind == 1) begin
      check(got_pte && pa_seen == exp, tag, pa_seen, exp);
      check(out_valid && out_pa == sg_pa(exp, a), "R8", out_pa, sg_pa(exp, a));
    end else begin
      if (kind == 3) check(got_pte && pa_seen == exp, tag, pa_seen, exp);
      check(fault && !out_valid, tag, {38'h0, out_valid, fault}, 40'h1);
      @(negedge clk);
      check(!fault, "R9", {39'h0, fault}, 40'h0);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!out_valid && !fault && !pte_req && req_ready, "R1",
          {36'h0, out_valid, fault, pte_req, req_ready}, 40'h1);
    run_req(32'h8000_0000, 8'h0, 0, 2, 40'h0, "R1");
    run_req(32'h0000_0000, 8'h5, 1, 2, 40'h0, "R1");

    // R2 programming
    cfg(0, 0, 32'h0080_0003); cfg(0, 1, 32'h007F_FFFF); cfg(0, 2, 32'h0010_0000);
    cfg(1, 0, 32'h8000_0001); cfg(1, 1, 32'h3FFF_FFFF); cfg(1, 2, 32'h1000_0000);
    cfg(2, 0, 32'hC000_0003); cfg(2, 1, 32'h3FFF_FFFF); cfg(2, 2, 32'h0020_0000);
    cfg(3, 0, 32'h0400_0001); cfg(3, 1, 32'h000F_FFFF); cfg(3, 2, 32'h0030_0000);

    for (int i = 0; i < NV; i++)
      run_req(V_ADDR[i], 8'h0, V_DAC[i], V_KIND[i], V_EXP[i], V_TAG[i]);

    // R10 bypass enabled
    cfg(0, 3, 32'h1);
    run_req(32'h0000_5678, 8'h12, 1, 0, 40'h12_0000_5678, "R10");
    run_req(32'h8000_0010, 8'h00, 0, 0, 40'h00_1000_0010, "R2");

    // R4 overlap: window 2 over window 1, lower wins
    cfg(2, 0, 32'h8000_0003);
    run_req(32'h8000_0100, 8'h0, 0, 0, 40'h00_1000_0100, "R4");
    cfg(1, 0, 32'h8000_0000);
    run_req(32'h8000_0100, 8'h0, 0, 1, 40'h00_0020_0000, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule